// File: doc/BRIEF.md
# Dual Zero-Overhead Loop Controller

This block sits beside the next-address logic of a program sequencer and removes the branch at the end of a counted loop. It holds two loop units. Each unit has a start address, an end address and an iteration counter. On every retired instruction the block compares the retired address with both end addresses. When a unit matches and still has two or more iterations left, the block tells the fetch stage to continue at that unit's start address and takes one off that unit's counter. The instruction at the end address always executes, including on the final pass.

Software arms a unit in one of two ways. The first is a single setup request, which gives the address of the setup instruction, two unsigned byte offsets and a count. The block then writes all three registers of the chosen unit in one cycle. The second is a write to one register at a time. Such a write goes straight in when the target unit is idle. When the unit is active, the block raises a stall request for a fixed number of cycles and applies the write at the end of that window.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset both units are idle: all six registers are zero, no retired address causes a redirect, and `stall` and `setup_err` are low.
- R2: In the same cycle that `exec_valid` is high, `exec_pc` equals a unit's end address and that unit's counter is 2 or more, `redir_valid` is high and `redir_addr` carries that unit's start address. In every other cycle `redir_valid` is low.
- R3: A redirect taken from a unit lowers that unit's counter by one at the next edge. When the end address retires with a counter of 1, the counter becomes 0, no redirect occurs and execution falls through. A loop armed with count N therefore runs its body N times.
- R4: When both units match the retired address and both have counters of 2 or more, unit 1 wins. `redir_addr` is unit 1's start address, and unit 0's counter does not change.
- R5: An accepted setup request loads the chosen unit in a single cycle. The start address becomes `setup_pc + setup_top_off`, the end address becomes `setup_pc + setup_bot_off`, and the counter becomes `setup_count`. The new values act from the next cycle on.
- R6: A setup request with `setup_top_off` above 30 or `setup_bot_off` above 2046 drives `setup_err` high in the same cycle and loads nothing. The values 30 and 2046 themselves are accepted.
- R7: A single-register write to a unit whose counter is zero takes effect at the next edge and raises no stall. The `wr_sel` codes are 0 for start, 1 for end, 2 for counter and 3 for reserved. A write with code 3 is dropped, changes no register and raises no stall.
- R8: A single-register write to a unit whose counter is non-zero holds `stall` high for exactly STALL_CYC cycles (default 4), starting in the next cycle. The register takes the new value at the edge that ends the last stall cycle.
- R9: While `stall` is high, setup requests and register writes are ignored. A write that arrives in the same cycle as a setup request is also dropped.
- R10: A setup with count 0 or 1 runs the body exactly once and produces no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| exec_valid | input | 1 | An instruction retires this cycle |
| exec_pc | input | ADDR_W | Address of the retiring instruction |
| setup_valid | input | 1 | Setup request for one unit |
| setup_unit | input | 1 | Unit addressed by the setup request |
| setup_pc | input | ADDR_W | Address of the setup instruction |
| setup_top_off | input | OFF_W | Unsigned byte offset to the loop start |
| setup_bot_off | input | OFF_W | Unsigned byte offset to the loop end |
| setup_count | input | CNT_W | Iteration count |
| wr_valid | input | 1 | Single-register write request |
| wr_unit | input | 1 | Unit addressed by the write |
| wr_sel | input | 2 | Register select: 0 start, 1 end, 2 counter, 3 reserved |
| wr_data | input | ADDR_W | Write data; the counter takes the low CNT_W bits |
| redir_valid | output | 1 | Fetch should continue at `redir_addr` |
| redir_addr | output | ADDR_W | Loop start address of the winning unit |
| stall | output | 1 | Stall request while a write to an active unit is pending |
| setup_err | output | 1 | The current setup request has an offset out of range |

## Verification
The checker watches several rules on every cycle. A redirect must appear exactly when a qualifying end-address match occurs, and unit 1 must win a shared end address. A taken redirect lowers the winner's counter by one, and the losing unit's counter holds. A rejected setup leaves all registers unchanged. Every stall burst lasts exactly STALL_CYC cycles. Other behaviour only shows up across whole scenarios in the bench: the number of body passes for counts of 0, 1 and 3, the interleaving of two nested loops that share an end address, the acceptance of the exact offset limits, a pending write landing at the end of its stall, and requests dropped while the stall is in progress.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  localparam int NUM_UNITS = 2;

  typedef enum logic [1:0] {
    LSEL_TOP = 2'd0,
    LSEL_BOT = 2'd1,
    LSEL_CNT = 2'd2,
    LSEL_RSV = 2'd3
  } lreg_sel_e;

endpackage

// File: rtl/hwloop_unit.sv
module hwloop_unit
  import hwloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_top,
  input  logic [ADDR_W-1:0] load_bot,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              wr_en,
  input  lreg_sel_e         wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              exec_valid,
  input  logic [ADDR_W-1:0] exec_pc,
  input  logic              dec_en,
  output logic [ADDR_W-1:0] top_q,
  output logic [ADDR_W-1:0] bot_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              qual,
  output logic              last,
  output logic              active
);

  logic              hit;
  logic              top_en, bot_en, cnt_en;
  logic [ADDR_W-1:0] top_d, bot_d;
  logic [CNT_W-1:0]  cnt_d;

  // end-address compare against the retiring instruction
  assign hit    = exec_valid && (exec_pc == bot_q);
  assign qual   = hit && (cnt_q >= CNT_W'(2));
  assign last   = hit && (cnt_q == CNT_W'(1));
  assign active = (cnt_q != '0);

  // next-state: setup load beats a single write, which beats a decrement
  always_comb begin
    top_en = load_en || (wr_en && wr_sel == LSEL_TOP);
    bot_en = load_en || (wr_en && wr_sel == LSEL_BOT);
    cnt_en = load_en || (wr_en && wr_sel == LSEL_CNT) || dec_en;
    top_d  = load_en ? load_top : wr_data;
    bot_d  = load_en ? load_bot : wr_data;
    if (load_en)                         cnt_d = load_cnt;
    else if (wr_en && wr_sel == LSEL_CNT) cnt_d = wr_data[CNT_W-1:0];
    else                                 cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      bot_q <= '0;
      cnt_q <= '0;
    end else begin
      if (top_en) top_q <= top_d;
      if (bot_en) bot_q <= bot_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/hwloop_setup_chk.sv
module hwloop_setup_chk #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int TOP_MAX = 30,
  parameter int BOT_MAX = 2046
) (
  input  logic [ADDR_W-1:0] setup_pc,
  input  logic [OFF_W-1:0]  top_off,
  input  logic [OFF_W-1:0]  bot_off,
  output logic              off_err,
  output logic [ADDR_W-1:0] top_addr,
  output logic [ADDR_W-1:0] bot_addr
);

  localparam logic [OFF_W-1:0] TOP_LIM = OFF_W'(TOP_MAX);
  localparam logic [OFF_W-1:0] BOT_LIM = OFF_W'(BOT_MAX);

  always_comb begin
    off_err  = (top_off > TOP_LIM) || (bot_off > BOT_LIM);
    top_addr = setup_pc + ADDR_W'(top_off);
    bot_addr = setup_pc + ADDR_W'(bot_off);
  end

endmodule

// File: rtl/hwloop_wr_stall.sv
module hwloop_wr_stall
  import hwloop_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int STALL_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic                 wr_unit,
  input  lreg_sel_e            wr_sel,
  input  logic [ADDR_W-1:0]    wr_data,
  input  logic                 setup_req,
  input  logic [NUM_UNITS-1:0] unit_active,
  output logic                 stall,
  output logic                 cm_en,
  output logic                 cm_unit,
  output lreg_sel_e            cm_sel,
  output logic [ADDR_W-1:0]    cm_data
);

  localparam int SW = $clog2(STALL_CYC + 1);

  logic [SW-1:0]     left_q, left_d;
  logic              left_en;
  logic              pend_unit_q;
  lreg_sel_e         pend_sel_q;
  logic [ADDR_W-1:0] pend_data_q;
  logic              accept, go;

  assign accept = wr_valid && !setup_req && (wr_sel != LSEL_RSV) && (left_q == '0);
  assign go     = accept && unit_active[wr_unit];
  assign stall  = (left_q != '0);

  always_comb begin
    left_en = go || (left_q != '0);
    left_d  = go ? SW'(STALL_CYC) : left_q - SW'(1);
  end

  // commit: pending write on last stall cycle, else a direct write to an idle unit
  always_comb begin
    cm_en   = 1'b0;
    cm_unit = wr_unit;
    cm_sel  = wr_sel;
    cm_data = wr_data;
    if (left_q == SW'(1)) begin
      cm_en   = 1'b1;
      cm_unit = pend_unit_q;
      cm_sel  = pend_sel_q;
      cm_data = pend_data_q;
    end else if (accept && !unit_active[wr_unit]) begin
      cm_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q      <= '0;
      pend_unit_q <= 1'b0;
      pend_sel_q  <= LSEL_TOP;
      pend_data_q <= '0;
    end else begin
      if (left_en) left_q <= left_d;
      if (go) begin
        pend_unit_q <= wr_unit;
        pend_sel_q  <= wr_sel;
        pend_data_q <= wr_data;
      end
    end
  end

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
  import hwloop_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int OFF_W     = 12,
  parameter int TOP_MAX   = 30,
  parameter int BOT_MAX   = 2046,
  parameter int STALL_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_valid,
  input  logic [ADDR_W-1:0] exec_pc,
  input  logic              setup_valid,
  input  logic              setup_unit,
  input  logic [ADDR_W-1:0] setup_pc,
  input  logic [OFF_W-1:0]  setup_top_off,
  input  logic [OFF_W-1:0]  setup_bot_off,
  input  logic [CNT_W-1:0]  setup_count,
  input  logic              wr_valid,
  input  logic              wr_unit,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              stall,
  output logic              setup_err
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // setup offset check
  logic              off_err;
  logic [ADDR_W-1:0] s_top, s_bot;
  logic              load_req;

  hwloop_setup_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .TOP_MAX(TOP_MAX),
    .BOT_MAX(BOT_MAX)
  ) setup_chk_i (
    .setup_pc(setup_pc),
    .top_off (setup_top_off),
    .bot_off (setup_bot_off),
    .off_err (off_err),
    .top_addr(s_top),
    .bot_addr(s_bot)
  );

  assign setup_err = setup_valid && off_err;
  assign load_req  = setup_valid && !off_err && !stall;

  // single-register write path with stall
  logic [NUM_UNITS-1:0] u_active;
  logic                 cm_en, cm_unit;
  lreg_sel_e            cm_sel;
  logic [ADDR_W-1:0]    cm_data;

  hwloop_wr_stall #(
    .ADDR_W   (ADDR_W),
    .STALL_CYC(STALL_CYC)
  ) wr_stall_i (
    .clk        (clk),
    .rst_n      (rst_i),
    .wr_valid   (wr_valid),
    .wr_unit    (wr_unit),
    .wr_sel     (lreg_sel_e'(wr_sel)),
    .wr_data    (wr_data),
    .setup_req  (setup_valid),
    .unit_active(u_active),
    .stall      (stall),
    .cm_en      (cm_en),
    .cm_unit    (cm_unit),
    .cm_sel     (cm_sel),
    .cm_data    (cm_data)
  );

  // loop units
  logic [ADDR_W-1:0]    u_top [NUM_UNITS];
  logic [ADDR_W-1:0]    u_bot [NUM_UNITS];
  logic [CNT_W-1:0]     u_cnt [NUM_UNITS];
  logic [NUM_UNITS-1:0] u_qual, u_last, u_win, u_dec;

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    hwloop_unit #(
      .ADDR_W(ADDR_W),
      .CNT_W (CNT_W)
    ) unit_i (
      .clk       (clk),
      .rst_n     (rst_i),
      .load_en   (load_req && (setup_unit == 1'(g))),
      .load_top  (s_top),
      .load_bot  (s_bot),
      .load_cnt  (setup_count),
      .wr_en     (cm_en && (cm_unit == 1'(g))),
      .wr_sel    (cm_sel),
      .wr_data   (cm_data),
      .exec_valid(exec_valid),
      .exec_pc   (exec_pc),
      .dec_en    (u_dec[g]),
      .top_q     (u_top[g]),
      .bot_q     (u_bot[g]),
      .cnt_q     (u_cnt[g]),
      .qual      (u_qual[g]),
      .last      (u_last[g]),
      .active    (u_active[g])
    );
  end

  // priority: unit 1 over unit 0
  always_comb begin
    u_win[1]    = u_qual[1];
    u_win[0]    = u_qual[0] && !u_qual[1];
    u_dec       = u_win | u_last;
    redir_valid = |u_qual;
    redir_addr  = u_qual[1] ? u_top[1] : u_top[0];
  end

endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  parameter int STALL_CYC = 4
) (
  input logic              clk,
  input logic              rst_i,
  input logic              exec_valid,
  input logic [ADDR_W-1:0] exec_pc,
  input logic              setup_valid,
  input logic              wr_valid,
  input logic              stall,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              setup_err,
  input logic [ADDR_W-1:0] top0,
  input logic [ADDR_W-1:0] top1,
  input logic [ADDR_W-1:0] bot0,
  input logic [ADDR_W-1:0] bot1,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1
);

  logic q0, q1, quiet;
  assign q0    = exec_valid && exec_pc == bot0 && cnt0 >= CNT_W'(2);
  assign q1    = exec_valid && exec_pc == bot1 && cnt1 >= CNT_W'(2);
  assign quiet = !stall && !setup_valid && !wr_valid;

  logic [31:0] run_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)     run_q <= '0;
    else if (stall) run_q <= run_q + 32'd1;
    else            run_q <= '0;
  end

  assert_redirect_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (q0 || q1) |-> redir_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_i)
    redir_valid |-> (q0 || q1));

  assert_priority_R4: assert property (@(posedge clk) disable iff (!rst_i)
    q1 |-> redir_addr == top1);

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (q1 && quiet) |=> cnt1 == $past(cnt1) - CNT_W'(1));

  assert_loser_hold_R4: assert property (@(posedge clk) disable iff (!rst_i)
    (q1 && q0 && quiet) |=> $stable(cnt0));

  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (setup_err && !wr_valid && !exec_valid && !stall) |=>
      ($stable(cnt0) && $stable(cnt1) && $stable(top0) && $stable(top1) &&
       $stable(bot0) && $stable(bot1)));

  assert_stall_len_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(stall) |-> run_q == 32'(STALL_CYC));

  assert_stall_cap_R8: assert property (@(posedge clk) disable iff (!rst_i)
    stall |-> run_q < 32'(STALL_CYC));

endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .STALL_CYC(STALL_CYC)
) chk_i (
  .clk        (clk),
  .rst_i      (rst_i),
  .exec_valid (exec_valid),
  .exec_pc    (exec_pc),
  .setup_valid(setup_valid),
  .wr_valid   (wr_valid),
  .stall      (stall),
  .redir_valid(redir_valid),
  .redir_addr (redir_addr),
  .setup_err  (setup_err),
  .top0       (u_top[0]),
  .top1       (u_top[1]),
  .bot0       (u_bot[0]),
  .bot1       (u_bot[1]),
  .cnt0       (u_cnt[0]),
  .cnt1       (u_cnt[1])
);

// File: tb/hwloop_ctrl_tb_top.sv
module hwloop_ctrl_tb_top;

  localparam int AW    = 32;
  localparam int CW    = 32;
  localparam int OW    = 12;
  localparam int STALL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exec_valid = 1'b0;
  logic [AW-1:0] exec_pc = '0;
  logic          setup_valid = 1'b0;
  logic          setup_unit = 1'b0;
  logic [AW-1:0] setup_pc = '0;
  logic [OW-1:0] setup_top_off = '0;
  logic [OW-1:0] setup_bot_off = '0;
  logic [CW-1:0] setup_count = '0;
  logic          wr_valid = 1'b0;
  logic          wr_unit = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [AW-1:0] wr_data = '0;
  logic          redir_valid, stall, setup_err;
  logic [AW-1:0] redir_addr;

  always #5 clk = ~clk;

  hwloop_ctrl #(.STALL_CYC(STALL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .exec_valid(exec_valid), .exec_pc(exec_pc),
    .setup_valid(setup_valid), .setup_unit(setup_unit), .setup_pc(setup_pc),
    .setup_top_off(setup_top_off), .setup_bot_off(setup_bot_off),
    .setup_count(setup_count),
    .wr_valid(wr_valid), .wr_unit(wr_unit), .wr_sel(wr_sel), .wr_data(wr_data),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .stall(stall), .setup_err(setup_err)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  longint m_top [2];
  longint m_bot [2];
  longint m_cnt [2];
  int     m_left = 0;
  int     p_unit, p_sel;
  longint p_data;

  function automatic void m_reset();
    for (int i = 0; i < 2; i++) begin m_top[i] = 0; m_bot[i] = 0; m_cnt[i] = 0; end
    m_left = 0;
  endfunction

  function automatic bit m_q(int u);
    return exec_valid && longint'(exec_pc) == m_bot[u] && m_cnt[u] >= 2;
  endfunction

  function automatic bit m_rv();
    return m_q(0) || m_q(1);
  endfunction

  function automatic longint m_ra();
    return m_q(1) ? m_top[1] : m_top[0];
  endfunction

  function automatic bit m_err();
    return setup_valid && (setup_top_off > 30 || setup_bot_off > 2046);
  endfunction

  function automatic void m_apply(int u, int sel, longint d);
    case (sel)
      0: m_top[u] = d;
      1: m_bot[u] = d;
      2: m_cnt[u] = d;
      default: ;
    endcase
  endfunction

  function automatic void m_step();
    bit q0, q1;
    q0 = m_q(0);
    q1 = m_q(1);
    for (int u = 0; u < 2; u++) begin
      bit hit;
      hit = exec_valid && longint'(exec_pc) == m_bot[u];
      if (hit && m_cnt[u] >= 2 && ((u == 1 && q1) || (u == 0 && q0 && !q1)))
        m_cnt[u] = m_cnt[u] - 1;
      else if (hit && m_cnt[u] == 1)
        m_cnt[u] = 0;
    end
    if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_apply(p_unit, p_sel, p_data);
    end else if (setup_valid) begin
      if (!m_err()) begin
        m_top[setup_unit] = (setup_pc + setup_top_off) & 64'hFFFF_FFFF;
        m_bot[setup_unit] = (setup_pc + setup_bot_off) & 64'hFFFF_FFFF;
        m_cnt[setup_unit] = setup_count;
      end
    end else if (wr_valid && wr_sel != 2'd3) begin
      if (m_cnt[wr_unit] != 0) begin
        m_left = STALL; p_unit = wr_unit; p_sel = wr_sel; p_data = wr_data;
      end else begin
        m_apply(wr_unit, wr_sel, wr_data);
      end
    end
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // one clock: compare outputs mid-phase, advance model at the edge, idle the inputs
  task automatic tick();
    #1;
    chk({cur_req, " redir_valid"}, redir_valid, m_rv());
    if (m_rv()) chk({cur_req, " redir_addr"}, redir_addr, m_ra());
    chk({cur_req, " stall"}, stall, m_left > 0);
    chk({cur_req, " setup_err"}, setup_err, m_err());
    @(posedge clk);
    if (rst_n) m_step();
    @(negedge clk);
    exec_valid = 0; setup_valid = 0; wr_valid = 0;
  endtask

  task automatic do_setup(bit u, longint pc, int toff, int boff, longint cnt);
    setup_valid = 1; setup_unit = u; setup_pc = AW'(pc);
    setup_top_off = OW'(toff); setup_bot_off = OW'(boff); setup_count = CW'(cnt);
    tick();
  endtask

  task automatic do_write(bit u, int sel, longint d);
    wr_valid = 1; wr_unit = u; wr_sel = 2'(sel); wr_data = AW'(d);
    tick();
  endtask

  task automatic do_exec(longint pc);
    exec_valid = 1; exec_pc = AW'(pc);
    tick();
  endtask

  // follow the program: next pc is the redirect target or the next word
  task automatic run_prog(longint start, longint stop, longint wa, longint wb,
                          output int ha, output int hb);
    longint pc, nxt;
    int guard;
    pc = start; ha = 0; hb = 0; guard = 0;
    while (pc != stop && guard < 500) begin
      if (pc == wa) ha++;
      if (pc == wb) hb++;
      exec_valid = 1; exec_pc = AW'(pc);
      nxt = m_rv() ? m_ra() : pc + 4;
      tick();
      pc = nxt;
      guard++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int ha, hb, st_cnt;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state, end address 0 with count 0 gives nothing
    cur_req = "R1";
    tick();
    do_exec(0);
    chk("R1 no redirect after reset", redir_valid, 0);

    // R5/R2/R3: count 3 loop, start 0x104, end 0x10C
    cur_req = "R5";
    do_setup(0, 'h100, 4, 12, 3);
    cur_req = "R2";
    run_prog('h104, 'h110, 'h104, 'h10C, ha, hb);
    chk("R3 body passes count 3", ha, 3);
    chk("R3 end instruction runs every pass", hb, 3);

    // R10: count 1 and count 0
    cur_req = "R10";
    do_setup(0, 'h100, 4, 12, 1);
    run_prog('h104, 'h110, 'h104, 'h10C, ha, hb);
    chk("R10 body once for count 1", ha, 1);
    do_setup(0, 'h100, 4, 12, 0);
    run_prog('h104, 'h110, 'h104, 'h10C, ha, hb);
    chk("R10 body once for count 0", ha, 1);

    // R4: shared end address 0x214, unit1 inner (top 0x208, count 2), unit0 outer (top 0x200, count 3)
    cur_req = "R4";
    do_setup(1, 'h200, 8, 20, 2);
    do_setup(0, 'h200, 0, 20, 3);
    run_prog('h200, 'h218, 'h200, 'h208, ha, hb);
    chk("R4 outer passes", ha, 3);
    chk("R4 inner passes", hb, 4);

    // R6: offset limits
    cur_req = "R6";
    do_setup(0, 'h300, 31, 8, 5);
    do_exec('h308);
    chk("R6 start offset 31 rejected", redir_valid, 0);
    do_setup(0, 'h300, 0, 2047, 5);
    do_exec('h300 + 2047);
    chk("R6 end offset 2047 rejected", redir_valid, 0);
    setup_valid = 1; setup_unit = 0; setup_pc = 'h300;
    setup_top_off = 30; setup_bot_off = 2046; setup_count = 2;
    #1 chk("R6 limits accepted", setup_err, 0);
    tick();
    exec_valid = 1; exec_pc = 'hAFE;
    #1 chk("R6 redirect at limit end", redir_addr, 'h31E);
    tick();
    do_exec('hAFE);

    // R7: writes to idle unit 1
    cur_req = "R7";
    do_write(1, 0, 'h400);
    do_write(1, 1, 'h40C);
    do_write(1, 2, 2);
    do_write(1, 3, 'h999);
    chk("R7 reserved code raises no stall", stall, 0);
    exec_valid = 1; exec_pc = 'h40C;
    #1 chk("R7 written loop redirects", redir_valid, 1);
    chk("R7 written start address", redir_addr, 'h400);
    tick();
    do_exec('h40C);

    // R8/R9: write to active unit 0
    cur_req = "R8";
    do_setup(0, 'h500, 0, 8, 5);
    do_write(0, 0, 'h540);
    st_cnt = 0;
    for (int k = 0; k < STALL + 3; k++) begin
      #1 if (stall) st_cnt++;
      if (k == 1) begin
        cur_req = "R9";
        setup_valid = 1; setup_unit = 0; setup_pc = 'h600;
        setup_top_off = 0; setup_bot_off = 4; setup_count = 0;
        wr_valid = 1; wr_unit = 0; wr_sel = 2; wr_data = 0;
      end
      tick();
      cur_req = "R8";
    end
    chk("R8 stall length", st_cnt, STALL);
    exec_valid = 1; exec_pc = 'h508;
    #1 chk("R9 requests during stall dropped", redir_valid, 1);
    chk("R8 delayed write landed", redir_addr, 'h540);
    tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule